// File: doc/BRIEF.md
# Centre-Aligned PWM Timer with Clock Prescaler

This block is a 16-bit timer that counts up from zero to a programmed top value and then back down to zero, over and over. It drives one pulse-width-modulated output pin. Because the count goes up and then down, each PWM period lasts twice the top value in timer ticks, and the pulses stay centred in the period. Three waveform shapes are available. In the "high-half" shape the down slope is always high, so the duty is at least one half. In the "low-half" shape the down slope is always low, so the duty is at most one half. In the "flip" shape the pin inverts at every compare match, and its duty depends on the level the pin starts at.

The timer ticks either from the system clock through a prescaler that divides by a power of four, or on falling edges of an external count pin. The external pin is synchronized and edge-detected inside the block. Software reaches the block over a simple synchronous register bus. A write takes effect at the clock edge where it is sampled, and a read returns data from the same cycle. Four registers are exposed: control, top value, compare value and live counter.

Top module: `updown_pwm_timer`

## Requirements
- R1: After reset the control, top, compare and counter registers (addresses 0, 1, 2, 3) read 0 and `pwm_out` is 0.
- R2: While running with top value T>0, the counter advances by one step per tick through 0,1,…,T,T-1,…,1,0,…, so one period is 2T ticks. The counter enters state k ticks after the run bit is written with the value k mod 2T when that is at most T, and 2T minus it otherwise. With T=0 the counter stays at 0.
- R3: Mode 01 (high-half): the output is high on the whole down slope, and on up-slope counts below the compare value C. It is high for T+min(C,T) of every 2T ticks.
- R4: Mode 10 (low-half): the output is high only on up-slope counts below C, which is min(C,T) of every 2T ticks.
- R5: Mode 11 (flip): while stopped the output equals control bit 6. While running it inverts on every tick that lands the counter on C, on both slopes. Starting from counter 0 with 0<C<T, the output is high for 2C of 2T ticks when bit 6 is 1, and for 2T-2C ticks when bit 6 is 0.
- R6: Control bits 3:1 pick the tick rate as the system clock divided by 1, 4, 16, 64, 256 and 1024 for codes 0 to 5, and divided by 1 for codes 6 and 7. The divider is held cleared while stopped, so the first counter step comes exactly one divide ratio after the run bit (bit 0) is set.
- R7: With control bit 15 set, the counter steps once per falling edge of `count_pin`. Rising edges and the prescaler have no effect.
- R8: With the run bit clear, the counter and output hold still, and a write to address 3 loads the counter and restarts it on the up slope.
- R9: Control bits 14:7 read 0. Bits 15 and 6:0 read back what was written.
- R10: Mode 00 drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 top, 2 compare, 3 counter |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| count_pin | input | 1 | External count input, asynchronous |
| pwm_out | output | 1 | PWM output pin |

## Verification
A wrong counter direction flag or a bad step shows at the counter register on the very next tick. The triangle sequence is compared value by value, so the fault appears there. A fault in the output logic appears within one period (2T ticks), because the high-cycle count over a full period is compared against closed-form duty formulas for every compare value from 0 to T+1. A divider that is not cleared, or that decodes the wrong ratio, moves the first and second counter steps away from the cycles the ratio predicts. A fault in the synchronizer or the edge detector changes the number of counted pulses.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;
    typedef enum logic [1:0] {
        PWM_OFF = 2'd0,
        PWM_SET = 2'd1,
        PWM_CLR = 2'd2,
        PWM_TOG = 2'd3
    } pwm_mode_e;

    typedef struct packed {
        logic      ext;
        logic      init;
        pwm_mode_e mode;
        logic [2:0] psel;
        logic      run;
    } ctrl_t;
endpackage

// File: rtl/updown_pwm_presc.sv
module updown_pwm_presc #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = 2 * MAX_SEL;

    logic [DIV_W-1:0] div_d, div_q, last;

    always_comb begin
        last = '0;
        if (sel_i <= SEL_W'(MAX_SEL)) begin
            last = DIV_W'((1 << (2 * int'(sel_i))) - 1);
        end
        tick_o = run_i && (div_q == last);
        if (!run_i || tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R6: a stopped timer leaves the divider at zero
    assert_div_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> div_q == '0);
endmodule

// File: rtl/updown_pwm_edge.sv
module updown_pwm_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-1:0], pin_i};
        fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R7: one falling edge yields a single-cycle count pulse
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/updown_pwm_core.sv
module updown_pwm_core
    import updown_pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    input  logic [W-1:0] cmp_i,
    input  pwm_mode_e    mode_i,
    input  logic         init_i,
    output logic [W-1:0] cnt_o,
    output logic         pin_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic         pin;
    } core_t;

    core_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = load_val_i;
            s_d.up  = 1'b1;
        end else if (tick_i) begin
            if (reload_i == '0) begin
                s_d.cnt = '0;
                s_d.up  = 1'b1;
            end else if (s_q.up) begin
                if (s_q.cnt >= reload_i) begin
                    s_d.cnt = s_q.cnt - ONE;
                    s_d.up  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                    s_d.up  = (s_q.cnt + ONE) != reload_i;
                end
            end else if (s_q.cnt <= ONE) begin
                s_d.cnt = '0;
                s_d.up  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end
        unique case (mode_i)
            PWM_OFF: s_d.pin = 1'b0;
            PWM_SET: s_d.pin = !s_d.up || (s_d.cnt < cmp_i);
            PWM_CLR: s_d.pin = s_d.up && (s_d.cnt < cmp_i);
            PWM_TOG: begin
                if (!run_i) s_d.pin = init_i;
                else if (tick_i && !load_i && s_d.cnt == cmp_i) s_d.pin = ~s_q.pin;
                else s_d.pin = s_q.pin;
            end
            default: s_d.pin = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{cnt: '0, up: 1'b1, pin: 1'b0};
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign pin_o = s_q.pin;

    // R2: a tick inside the range moves the count by exactly one
    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && reload_i != '0 && s_q.cnt <= reload_i && (s_q.up || s_q.cnt != '0))
        |=> (s_q.cnt == $past(s_q.cnt) + ONE) || (s_q.cnt == $past(s_q.cnt) - ONE));
    // R8: without tick or load the counter holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(s_q.cnt));
    // R3: down slope is high in high-half mode
    assert_set_down_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == PWM_SET && !s_q.up) |-> s_q.pin);
    // R4: down slope is low in low-half mode
    assert_clr_down_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == PWM_CLR && !s_q.up) |-> !s_q.pin);
    // R5: a stopped flip-mode pin shows the chosen start level
    assert_tog_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == PWM_TOG && !$past(run_i)) |-> s_q.pin == $past(init_i));
    // R10: off mode keeps the pin low
    assert_off_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == PWM_OFF) |-> !s_q.pin);
endmodule

// File: rtl/updown_pwm_timer.sv
module updown_pwm_timer
    import updown_pwm_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_PSEL    = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         count_pin,
    output logic         pwm_out
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] reload;
        logic [W-1:0] cmp;
    } regs_t;

    regs_t        r_d, r_q;
    logic         presc_tick, pin_fall, tick, load;
    logic [W-1:0] cnt;
    logic [15:0]  ctrl_rd;
    logic         unused_wbits;

    assign unused_wbits = ^bus_wdata[14:7];

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            unique case (bus_addr)
                2'd0: begin
                    r_d.ctrl.run  = bus_wdata[0];
                    r_d.ctrl.psel = bus_wdata[3:1];
                    r_d.ctrl.mode = pwm_mode_e'(bus_wdata[5:4]);
                    r_d.ctrl.init = bus_wdata[6];
                    r_d.ctrl.ext  = bus_wdata[15];
                end
                2'd1:    r_d.reload = bus_wdata;
                2'd2:    r_d.cmp    = bus_wdata;
                default: ;
            endcase
        end
        load    = bus_we && (bus_addr == 2'd3);
        tick    = r_q.ctrl.run && (r_q.ctrl.ext ? pin_fall : presc_tick);
        ctrl_rd = {r_q.ctrl.ext, 8'h00, r_q.ctrl.init, r_q.ctrl.mode,
                   r_q.ctrl.psel, r_q.ctrl.run};
        unique case (bus_addr)
            2'd0:    bus_rdata = W'(ctrl_rd);
            2'd1:    bus_rdata = r_q.reload;
            2'd2:    bus_rdata = r_q.cmp;
            default: bus_rdata = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    updown_pwm_presc #(.SEL_W(3), .MAX_SEL(MAX_PSEL)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.ctrl.run && !r_q.ctrl.ext),
        .sel_i  (r_q.ctrl.psel),
        .tick_o (presc_tick)
    );

    updown_pwm_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (count_pin),
        .fall_o (pin_fall)
    );

    updown_pwm_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (r_q.ctrl.run),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (bus_wdata),
        .reload_i   (r_q.reload),
        .cmp_i      (r_q.cmp),
        .mode_i     (r_q.ctrl.mode),
        .init_i     (r_q.ctrl.init),
        .cnt_o      (cnt),
        .pin_o      (pwm_out)
    );

    // R9: the unassigned control bits read as zero
    assert_ctrl_gap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> bus_rdata[14:13] == 2'b00);
    // R7: in external mode a count step needs a synchronized falling edge
    assert_ext_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl.ext && !pin_fall && !load) |=> $stable(cnt));
endmodule

// File: tb/sim_updown_pwm_timer.sv
module sim_updown_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        count_pin = 1'b1;
    logic        pwm_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    updown_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_pin(count_pin), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    function automatic logic [15:0] ctl(input bit ext, input bit init, input int mode,
                                        input int psel, input bit run);
        return {ext, 8'h00, init, 2'(mode), 3'(psel), run};
    endfunction

    // stop, load counter 0, program top/compare, set mode, then run at divide-by-1
    task automatic prep(input int t, input int c, input int mode, input bit init);
        wr(2'd0, ctl(0, init, mode, 0, 0));
        wr(2'd3, 16'd0);
        wr(2'd1, 16'(t));
        wr(2'd2, 16'(c));
        wr(2'd0, ctl(0, init, mode, 0, 1));
    endtask

    task automatic duty(input int t, input int c, input int mode, input bit init,
                        input int exp, input string tag);
        int hi;
        prep(t, c, mode, init);
        repeat (2 * t) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 2 * t; i++) begin
            @(negedge clk);
            hi += int'(pwm_out);
        end
        chk(hi == exp, tag, hi, exp);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, v2, p, first, second, lim;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk(pwm_out == 1'b0, "R1 pwm reset", int'(pwm_out), 0);

        // R9: control readback mask
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v);
        chk(v == 16'h807F, "R9 control readback", v, 16'h807F);
        wr(2'd0, 16'h0000);
        rd(2'd0, v);
        chk(v == 0, "R9 control cleared", v, 0);

        // R2: triangle sequence, T=4 and T=3
        for (int t = 3; t <= 4; t++) begin
            prep(t, 0, 0, 0);
            bus_addr = 2'd3;
            for (int k = 1; k <= 4 * t + 2; k++) begin
                @(negedge clk);
                #1 v = int'(bus_rdata);
                p = k % (2 * t);
                p = (p <= t) ? p : 2 * t - p;
                chk(v == p, "R2 count sequence", v, p);
            end
        end
        // R2: top value zero holds at zero
        prep(0, 0, 0, 0);
        repeat (10) @(negedge clk);
        rd(2'd3, v);
        chk(v == 0, "R2 zero top holds", v, 0);

        // R3 / R4: sweep compare across 0..T+1 with T=5
        for (int c = 0; c <= 6; c++) begin
            duty(5, c, 1, 0, 5 + ((c < 5) ? c : 5), "R3 high-half duty");
            duty(5, c, 2, 0, (c < 5) ? c : 5, "R4 low-half duty");
        end
        // R5: flip mode with both start levels
        for (int c = 1; c <= 4; c++) begin
            duty(5, c, 3, 1, 2 * c, "R5 flip duty start high");
            duty(5, c, 3, 0, 10 - 2 * c, "R5 flip duty start low");
        end
        wr(2'd0, ctl(0, 1, 3, 0, 0));
        @(negedge clk);
        chk(pwm_out == 1'b1, "R5 stopped flip level", int'(pwm_out), 1);

        // R10: off mode stays low
        duty(5, 3, 0, 0, 0, "R10 off mode low");

        // R6: divide ratio for every select code, counted from the run write
        for (int s = 0; s < 8; s++) begin
            lim = (s <= 5) ? (1 << (2 * s)) : 1;
            wr(2'd0, ctl(0, 0, 0, s, 0));
            wr(2'd3, 16'd0);
            wr(2'd1, 16'd5000);
            wr(2'd0, ctl(0, 0, 0, s, 1));
            bus_addr = 2'd3;
            first = -1; second = -1;
            for (int k = 1; k <= 2 * lim + 2; k++) begin
                @(negedge clk);
                #1 v = int'(bus_rdata);
                if (first < 0 && v == 1) first = k;
                if (second < 0 && v == 2) second = k;
            end
            chk(first == lim, "R6 first step", first, lim);
            chk(second == 2 * lim, "R6 second step", second, 2 * lim);
        end

        // R8: stop freezes counter and output; load while stopped
        prep(5, 2, 1, 0);
        repeat (7) @(negedge clk);
        wr(2'd0, ctl(0, 0, 1, 0, 0));
        rd(2'd3, v);
        p = int'(pwm_out);
        repeat (20) @(negedge clk);
        rd(2'd3, v2);
        chk(v2 == v, "R8 counter frozen", v2, v);
        chk(int'(pwm_out) == p, "R8 output frozen", int'(pwm_out), p);
        wr(2'd3, 16'd3);
        rd(2'd3, v);
        chk(v == 3, "R8 counter load", v, 3);

        // R7: external falling edges only
        wr(2'd3, 16'd0);
        wr(2'd1, 16'd1000);
        wr(2'd0, ctl(1, 0, 0, 0, 1));
        for (int n = 0; n < 7; n++) begin
            @(negedge clk); count_pin = 1'b0;
            repeat (4) @(negedge clk);
            count_pin = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(2'd3, v);
        chk(v == 7, "R7 falling edge count", v, 7);
        repeat (50) @(negedge clk);
        rd(2'd3, v);
        chk(v == 7, "R7 no count while pin steady", v, 7);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule